// File: doc/BRIEF.md
# Column-Indexed Cache-Line Word Shuffler

This block sits in a memory controller, between the line buffer and the data pins of a rank of eight DRAM chips that always act together. A cache line is eight chip-sized words, and lane j of the line is the word that chip j carries. Before a line is written, the block reorders its words with a three-stage butterfly network. Each stage is switched on by one of the low three bits of the line's DRAM column address. When a line is read back, the same network, driven by the same column bits, puts the words back in their original order.

Because the reordering depends on the column, consecutive lines are spread over the chips in different ways. The words picked out by a power-of-two stride through memory therefore end up on different chips, so a single column command can fetch all of them. The direction flag marks the line as write data or read data and travels with it. The network gives the same reordering for both directions, because every stage undoes itself. The output has an optional register stage with a valid/ready handshake.

Top module: `cl_shuffle`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `out_valid` is 0.
- R2: A line with column field 0 leaves the block with every word in its original lane.
- R3: Lane j of the output holds input lane (j XOR col). Word k occupies bits [k*WORD_W +: WORD_W], and lane index equals chip index. Bit 0 of col swaps neighbouring words, bit 1 swaps adjacent word pairs, and bit 2 swaps the two halves of four words.
- R4: Passing a line to the DRAM side and then passing the result back through the block with the same column field gives the original line.
- R5: The direction flag (0 = toward DRAM, 1 = from DRAM) does not change the reordering. `out_dir` carries the flag of the line that is being presented.
- R6: Lines at columns 0 to 7 hold logical element c*8+k in word k. For strides 2, 4 and 8, the eight elements starting at element 0 sit on eight distinct chips after shuffling.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_line` and `out_dir` stay unchanged, and no accepted line is lost or duplicated.
- R8: With the output register present, `in_ready` is 1 exactly when the register is empty or its content is taken in the same cycle.
- R9: A line accepted on a clock edge is presented at the output from the next edge on (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input line is present |
| in_ready | output | 1 | Block can take an input line |
| in_col | input | 3 | Low three bits of the line's DRAM column address |
| in_dir | input | 1 | 0 = toward DRAM, 1 = from DRAM |
| in_line | input | 8*WORD_W | Eight words, word k in lane k |
| out_valid | output | 1 | Output line is present |
| out_ready | input | 1 | Consumer takes the output line |
| out_dir | output | 1 | Direction flag of the presented line |
| out_line | output | 8*WORD_W | Reordered line |

## Verification
Lines built from distinct tagged words are sent at every column value. A wrong source lane or a stage tied to the wrong column bit then shows up as a misplaced word, not a hidden duplicate. Column 0, the three single-bit columns and the mixed columns separate an identity fault from a fault in one particular stage. Round trips in both directions and a stride-gather map over eight tagged lines test the property the block exists for. A stalled consumer and a random ready pattern test that lines are held and kept in order under backpressure.

// File: rtl/cl_shuffle_pkg.sv
// Package: cl_shuffle_pkg
// Shared sizing for the cache-line shuffler. The rank is eight chips wide,
// and the column field has as many bits as there are butterfly stages.
package cl_shuffle_pkg;
    localparam int LANES  = 8;
    localparam int STAGES = $clog2(LANES);
    localparam int COL_W  = STAGES;
endpackage

// File: rtl/cl_shuffle_stage.sv
// Module: cl_shuffle_stage
// One butterfly stage. When en is 1, each lane i takes its word from lane
// (i XOR GROUP), which swaps adjacent blocks of GROUP words. When en is 0,
// the line passes through unchanged.
// Assumes: GROUP is a power of two below LANES.
module cl_shuffle_stage #(
    parameter int WORD_W = 64,
    parameter int LANES  = 8,
    parameter int GROUP  = 1
) (
    input  logic                      en,
    input  logic [LANES*WORD_W-1:0]   din,
    output logic [LANES*WORD_W-1:0]   dout
);
    // Per-lane two-way select between the own word and the partner word.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int SRC = i ^ GROUP;
        assign dout[i*WORD_W +: WORD_W] = en ? din[SRC*WORD_W +: WORD_W]
                                             : din[i*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/cl_shuffle_net.sv
// Module: cl_shuffle_net
// Chain of butterfly stages. Stage k is enabled by col bit k and swaps
// blocks of 2^k words. The stages commute and each undoes itself, so the
// chain serves both write and read data.
// Assumes: col is stable while din is in use (purely combinational).
module cl_shuffle_net
    import cl_shuffle_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic [COL_W-1:0]          col,
    input  logic [LANES*WORD_W-1:0]   din,
    output logic [LANES*WORD_W-1:0]   dout
);
    localparam int LINE_W = LANES * WORD_W;

    logic [LINE_W-1:0] chain [0:STAGES];

    assign chain[0] = din;

    // One stage per column bit, each with its own block size.
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        cl_shuffle_stage #(
            .WORD_W (WORD_W),
            .LANES  (LANES),
            .GROUP  (1 << k)
        ) u_stage (
            .en   (col[k]),
            .din  (chain[k]),
            .dout (chain[k+1])
        );
    end

    assign dout = chain[STAGES];

    // XOR of all words in a line; any reordering leaves it unchanged.
    function automatic logic [WORD_W-1:0] fold_words(input logic [LINE_W-1:0] v);
        logic [WORD_W-1:0] acc;
        acc = '0;
        for (int w = 0; w < LANES; w++) acc ^= v[w*WORD_W +: WORD_W];
        return acc;
    endfunction

    // Check that the stage chain only moves words and never alters one (R3).
    always_comb begin
        a_r3_words_kept: assert (fold_words(din) == fold_words(dout))
            else $error("R3: shuffle network altered word content");
    end
endmodule

// File: rtl/cl_shuffle_outreg.sv
// Module: cl_shuffle_outreg
// Output stage with a valid/ready handshake. With PIPE = 1 it holds one line
// and accepts a new one whenever it is empty or being drained. With PIPE = 0
// it is a wire-through with no storage.
// Assumes: the upstream side keeps its data stable while in_valid waits.
module cl_shuffle_outreg #(
    parameter int LINE_W = 512,
    parameter bit PIPE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_dir,
    input  logic [LINE_W-1:0] in_line,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_dir,
    output logic [LINE_W-1:0] out_line
);
    if (PIPE) begin : g_reg
        logic              vld_q;
        logic              dir_q;
        logic [LINE_W-1:0] line_q;

        assign in_ready  = !vld_q || out_ready;
        assign out_valid = vld_q;
        assign out_dir   = dir_q;
        assign out_line  = line_q;

        // Occupancy flag: refill or empty on each accepted cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)        vld_q <= 1'b0;
            else if (in_ready) vld_q <= in_valid;
        end

        // Payload capture on an accepted input.
        always_ff @(posedge clk) begin
            if (in_valid && in_ready) begin
                line_q <= in_line;
                dir_q  <= in_dir;
            end
        end

        // A stalled output keeps presenting its line (R7).
        a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !out_ready |=> out_valid)
            else $error("R7: output valid dropped under backpressure");

        // A stalled output keeps its payload unchanged (R7).
        a_r7_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !out_ready |=> $stable(out_line) && $stable(out_dir))
            else $error("R7: output payload changed under backpressure");

        // An accepted line shows up on the following cycle (R9).
        a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_ready |=> out_valid)
            else $error("R9: accepted line not presented next cycle");
    end else begin : g_wire
        assign in_ready  = out_ready;
        assign out_valid = in_valid;
        assign out_dir   = in_dir;
        assign out_line  = in_line;
    end
endmodule

// File: rtl/cl_shuffle.sv
// Module: cl_shuffle
// Top of the column-indexed cache-line shuffler. The line goes through the
// butterfly network, steered by the low column bits, and then through the
// optional output register.
// Assumes: the eight chips of the rank map to lanes 0..7 of the line.
module cl_shuffle
    import cl_shuffle_pkg::*;
#(
    parameter int WORD_W  = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [COL_W-1:0]          in_col,
    input  logic                      in_dir,
    input  logic [LANES*WORD_W-1:0]   in_line,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic                      out_dir,
    output logic [LANES*WORD_W-1:0]   out_line
);
    localparam int LINE_W = LANES * WORD_W;

    logic [LINE_W-1:0] net_line;

    // Reordering network; direction needs no separate path.
    cl_shuffle_net #(
        .WORD_W (WORD_W)
    ) u_net (
        .col  (in_col),
        .din  (in_line),
        .dout (net_line)
    );

    // Handshake and optional storage at the output.
    cl_shuffle_outreg #(
        .LINE_W (LINE_W),
        .PIPE   (OUT_REG)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_dir    (in_dir),
        .in_line   (net_line),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_dir   (out_dir),
        .out_line  (out_line)
    );

    if (OUT_REG) begin : g_chk
        // Column 0 lines come out unchanged one cycle later (R2).
        a_r2_identity: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && in_ready && (in_col == '0) |=> out_line == $past(in_line))
            else $error("R2: column 0 line was reordered");
    end
endmodule

// File: tb/cl_shuffle_tb_top.sv
module cl_shuffle_tb_top;
    localparam int W  = 64;
    localparam int L  = 8;
    localparam int LW = W * L;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [2:0]    in_col = '0;
    logic          in_dir = 1'b0;
    logic [LW-1:0] in_line = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic          out_dir;
    logic [LW-1:0] out_line;

    typedef struct packed {
        logic          dir;
        logic [LW-1:0] line;
    } item_t;

    item_t         exp_q[$];
    int            checks = 0;
    int            errors = 0;
    logic [LW-1:0] last_out = '0;
    int            rdy_mode = 1;
    logic [7:0]    lfsr = 8'hA5;

    always #5 clk = ~clk;

    cl_shuffle #(.WORD_W(W), .OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_col(in_col), .in_dir(in_dir), .in_line(in_line),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_dir(out_dir), .out_line(out_line)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference reordering from R3: output lane j takes input lane j^col.
    function automatic logic [LW-1:0] model(input logic [LW-1:0] v, input logic [2:0] col);
        logic [LW-1:0] r;
        for (int j = 0; j < L; j++) r[j*W +: W] = v[(j ^ int'(col))*W +: W];
        return r;
    endfunction

    function automatic logic [LW-1:0] rand_line();
        logic [LW-1:0] r;
        for (int j = 0; j < L; j++) r[j*W +: W] = {$urandom(), $urandom()};
        return r;
    endfunction

    // Driver: queue the expected item, then hold the input until accepted.
    task automatic send(input logic [2:0] col, input logic dir,
                        input logic [LW-1:0] line, input logic [LW-1:0] exp_line);
        item_t it;
        @(posedge clk); #1;
        it.dir = dir; it.line = exp_line;
        exp_q.push_back(it);
        in_valid = 1'b1; in_col = col; in_dir = dir; in_line = line;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Consumer ready pattern, changed just after each edge.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            0:       out_ready = 1'b0;
            1:       out_ready = 1'b1;
            default: out_ready = lfsr[0];
        endcase
    end

    // Monitor: pop and compare on every output transfer.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7", "unexpected output line", out_line, '0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(out_line == e.line, "R3", "line order", out_line, e.line);
                check(out_dir == e.dir, "R5", "direction flag", LW'(out_dir), LW'(e.dir));
                last_out = out_line;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [LW-1:0] tag_line [0:7];
        logic [LW-1:0] a, b;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid in reset", LW'(out_valid), '0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid after reset", LW'(out_valid), '0);
        check(in_ready == 1'b1, "R8", "ready when empty", LW'(in_ready), LW'(1));

        // R2: column 0 is the identity in both directions
        a = rand_line();
        send(3'd0, 1'b0, a, a);
        send(3'd0, 1'b1, a, a);
        drain();
        check(last_out == a, "R2", "column 0 identity", last_out, a);

        // R3: every column, tagged words so misplacement is visible
        for (int c = 0; c < 8; c++) begin
            for (int j = 0; j < L; j++) a[j*W +: W] = {32'hC0DE0000 + 32'(j), 32'(c)};
            send(3'(c), 1'b0, a, model(a, 3'(c)));
        end
        drain();
        check(last_out[W-1:0] == {32'hC0DE0007, 32'd7}, "R3", "col 7 lane 0 from lane 7",
              LW'(last_out[W-1:0]), LW'({32'hC0DE0007, 32'd7}));

        // R5: direction leaves the reordering unchanged
        a = rand_line();
        send(3'd5, 1'b0, a, model(a, 3'd5));
        send(3'd5, 1'b1, a, model(a, 3'd5));
        drain();

        // R4: round trip in both direction orders
        for (int c = 1; c < 8; c += 2) begin
            a = rand_line();
            send(3'(c), 1'b0, a, model(a, 3'(c)));
            drain();
            b = last_out;
            send(3'(c), 1'b1, b, a);
            drain();
            check(last_out == a, "R4", "round trip restores line", last_out, a);
        end

        // R6: strided gather lands on distinct chips
        for (int c = 0; c < 8; c++) begin
            for (int j = 0; j < L; j++) a[j*W +: W] = W'(c*8 + j);
            send(3'(c), 1'b0, a, model(a, 3'(c)));
            drain();
            tag_line[c] = last_out;
        end
        for (int s = 2; s <= 8; s *= 2) begin
            logic [7:0] mask;
            mask = '0;
            for (int k = 0; k < 8; k++) begin
                int e;
                e = k * s;
                for (int j = 0; j < L; j++)
                    if (tag_line[e/8][j*W +: W] == W'(e)) mask[j] = 1'b1;
            end
            check(mask == 8'hFF, "R6", $sformatf("stride %0d chip spread", s),
                  LW'(mask), LW'(8'hFF));
        end

        // R7/R8/R9: stalled consumer
        rdy_mode = 0;
        repeat (2) @(posedge clk);
        a = rand_line();
        send(3'd3, 1'b1, a, model(a, 3'd3));
        @(negedge clk);
        check(out_valid == 1'b1, "R9", "presented after one cycle", LW'(out_valid), LW'(1));
        check(in_ready == 1'b0, "R8", "ready low when full and stalled", LW'(in_ready), '0);
        b = out_line;
        check(b == model(a, 3'd3), "R9", "presented line", b, model(a, 3'd3));
        repeat (3) begin
            @(negedge clk);
            check(out_valid == 1'b1 && out_line == b && out_dir == 1'b1, "R7",
                  "held under stall", out_line, b);
        end
        rdy_mode = 1;
        drain();

        // R7: random backpressure, random traffic, order kept
        rdy_mode = 2;
        for (int n = 0; n < 24; n++) begin
            logic [2:0] c;
            c = 3'($urandom_range(0, 7));
            a = rand_line();
            send(c, 1'($urandom_range(0, 1)), a, model(a, c));
        end
        rdy_mode = 1;
        drain();
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0 && out_valid == 1'b0, "R7", "no lost or extra lines",
              LW'(exp_q.size()), '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule